// File: doc/BRIEF.md
# Flat Access Aperture Router

This block sits in front of a vector memory pipeline and sorts each flat memory access by where it lands. It sends the access to the on-chip shared memory (LDS), to per-work-item private scratch, or on to global memory. It also flags accesses that cannot be served. Both the first and the last byte of the payload are classified. An access is flagged if either byte lands in the unmapped middle of the 64-bit space, or if the two bytes land in different regions.

Two configuration bits select the mode. When the compute-translation bit is set together with the narrow-pointer bit, the block runs in 32-bit mode. In that mode only the low 32 address bits are used. Each aperture is then a fixed 64 KB window, and a zero base turns the aperture off. In every other mode the block works on full 64-bit addresses, with base and limit registers that are each 64 KB aligned. The result is registered, so it appears one clock after the request.

Top module: `flat_aperture_router`

## Requirements
- R1: During and right after reset, `rsp_valid` is 0, `rsp_target` is 0 (none), `rsp_viol` is 0 and both offsets are 0.
- R2: `rsp_valid` equals `req_valid` delayed by one clock. While `rsp_valid` is 0, `rsp_target`, `rsp_viol` and both offsets are 0.
- R3: In 64-bit mode an aperture spans `{base_hi,16'h0000}` through `{limit_hi,16'hFFFF}`, and both ends are included. An access inside the shared aperture gives target code 1 (LDS) and `rsp_lds_off` = address − shared base. The other offset is 0 whenever the target is not the one it belongs to.
- R4: An access inside the private aperture gives target code 2. `rsp_priv_off` = `req_tid` × `cfg_stride` + (address − private base).
- R5: An access that hits no aperture and is not in the hole gives target code 3 (global), with both offsets 0 and no violation.
- R6: In 64-bit mode, address bits [63:47] that are neither all zero nor all one, outside every aperture, mark the hole. A first or last byte in the hole sets `rsp_viol`, and the target becomes 0 with both offsets 0.
- R7: The last byte is address + `req_bytes` − 1, and a size of 0 counts as 1 byte. If the first and last byte fall in different regions (shared, private, global), `rsp_viol` is set and the target becomes 0.
- R8: 32-bit mode applies when `cfg_atc`=1 and `cfg_ptr32`=1. Address bits [63:32] are ignored, and there is no hole. Each aperture base comes from bits [15:0] of its base register (address bits 31:16). The aperture is exactly 64 KB, the limit register is ignored, and a zero base disables it.
- R9: When `cfg_atc`=0, `cfg_ptr32` has no effect and the block runs in 64-bit mode.
- R10: If the shared and private apertures overlap, an address in both goes to the shared aperture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | First byte address |
| req_bytes | input | SIZE_W | Payload size in bytes (0 counts as 1) |
| req_tid | input | TID_W | Work-item id |
| cfg_atc | input | 1 | Compute-translation mode bit |
| cfg_ptr32 | input | 1 | Narrow-pointer bit |
| cfg_sh_base | input | 48 | Shared aperture base, address bits 63:16 |
| cfg_sh_limit | input | 48 | Shared aperture limit, address bits 63:16 |
| cfg_pr_base | input | 48 | Private aperture base, address bits 63:16 |
| cfg_pr_limit | input | 48 | Private aperture limit, address bits 63:16 |
| cfg_stride | input | STRIDE_W | Private bytes per work-item |
| rsp_valid | output | 1 | Result present |
| rsp_target | output | 2 | 0 none, 1 LDS, 2 private, 3 global |
| rsp_lds_off | output | LDS_W | Offset into the LDS |
| rsp_priv_off | output | POFF_W | Expanded private offset |
| rsp_viol | output | 1 | Memory violation |

## Verification
The bench probes both inclusive ends of each aperture. A design that compares with the wrong bound would send the last or first 64 KB granule to global memory. Payloads that run from an aperture or the low canonical half into the hole must be flagged. A design that only checks the first byte would let them through, and a design that ignores a zero size would compute a last byte below the first. In 32-bit mode the bench sets junk upper address bits, a large limit register and a zero base to expose a design that keeps 64-bit decoding, limit-based sizing or an always-on aperture. The bench also runs a 64-bit case with the narrow bit set and an overlap case, where a wrong mode decode or a private-first priority changes the target.

// File: rtl/flat_aperture_router.sv
module flat_aperture_router #(
  parameter int SIZE_W   = 8,
  parameter int TID_W    = 10,
  parameter int STRIDE_W = 16,
  parameter int LDS_W    = 32,
  parameter int POFF_W   = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [63:0]         req_addr,
  input  logic [SIZE_W-1:0]   req_bytes,
  input  logic [TID_W-1:0]    req_tid,
  input  logic                cfg_atc,
  input  logic                cfg_ptr32,
  input  logic [47:0]         cfg_sh_base,
  input  logic [47:0]         cfg_sh_limit,
  input  logic [47:0]         cfg_pr_base,
  input  logic [47:0]         cfg_pr_limit,
  input  logic [STRIDE_W-1:0] cfg_stride,
  output logic                rsp_valid,
  output logic [1:0]          rsp_target,
  output logic [LDS_W-1:0]    rsp_lds_off,
  output logic [POFF_W-1:0]   rsp_priv_off,
  output logic                rsp_viol
);

  localparam logic [1:0] T_NONE = 2'd0;
  localparam logic [1:0] T_LDS  = 2'd1;
  localparam logic [1:0] T_PRIV = 2'd2;
  localparam logic [1:0] T_GLB  = 2'd3;

  localparam logic [1:0] RG_GLB  = 2'd0;
  localparam logic [1:0] RG_SH   = 2'd1;
  localparam logic [1:0] RG_PR   = 2'd2;
  localparam logic [1:0] RG_HOLE = 2'd3;

  logic        mode32;
  logic [63:0] first_a, last_a, span;
  logic [63:0] sh_lo, sh_hi, pr_lo, pr_hi;
  logic        sh_en, pr_en;
  logic [1:0]  rg_first, rg_last;
  logic        viol_d;
  logic [1:0]  target_d;
  logic [63:0] sh_delta, pr_delta;
  logic [POFF_W-1:0] priv_d;

  assign mode32  = cfg_atc & cfg_ptr32;
  assign first_a = mode32 ? {32'h0, req_addr[31:0]} : req_addr;
  assign span    = (req_bytes == '0) ? 64'd0 : {{(64-SIZE_W){1'b0}}, req_bytes} - 64'd1;
  assign last_a  = first_a + span;

  assign sh_en = mode32 ? (cfg_sh_base[15:0] != 16'h0) : 1'b1;
  assign pr_en = mode32 ? (cfg_pr_base[15:0] != 16'h0) : 1'b1;
  assign sh_lo = mode32 ? {32'h0, cfg_sh_base[15:0], 16'h0000} : {cfg_sh_base, 16'h0000};
  assign sh_hi = mode32 ? {32'h0, cfg_sh_base[15:0], 16'hFFFF} : {cfg_sh_limit, 16'hFFFF};
  assign pr_lo = mode32 ? {32'h0, cfg_pr_base[15:0], 16'h0000} : {cfg_pr_base, 16'h0000};
  assign pr_hi = mode32 ? {32'h0, cfg_pr_base[15:0], 16'hFFFF} : {cfg_pr_limit, 16'hFFFF};

  function automatic logic [1:0] classify(input logic [63:0] a, input logic m32,
                                          input logic se, input logic [63:0] slo, input logic [63:0] shi,
                                          input logic pe, input logic [63:0] plo, input logic [63:0] phi);
    logic hole;
    hole = !m32 && (a[63:47] != 17'h0) && (a[63:47] != 17'h1FFFF);
    if (se && a >= slo && a <= shi)      classify = RG_SH;
    else if (pe && a >= plo && a <= phi) classify = RG_PR;
    else if (hole)                       classify = RG_HOLE;
    else                                 classify = RG_GLB;
  endfunction

  assign rg_first = classify(first_a, mode32, sh_en, sh_lo, sh_hi, pr_en, pr_lo, pr_hi);
  assign rg_last  = classify(last_a,  mode32, sh_en, sh_lo, sh_hi, pr_en, pr_lo, pr_hi);

  assign viol_d = (rg_first != rg_last) || (rg_first == RG_HOLE) || (rg_last == RG_HOLE);

  always_comb begin
    target_d = T_NONE;
    if (!viol_d) begin
      case (rg_first)
        RG_SH:   target_d = T_LDS;
        RG_PR:   target_d = T_PRIV;
        RG_GLB:  target_d = T_GLB;
        default: target_d = T_NONE;
      endcase
    end
  end

  assign sh_delta = first_a - sh_lo;
  assign pr_delta = first_a - pr_lo;
  assign priv_d   = POFF_W'(req_tid) * POFF_W'(cfg_stride) + pr_delta[POFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_target   <= T_NONE;
      rsp_lds_off  <= '0;
      rsp_priv_off <= '0;
      rsp_viol     <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_target   <= req_valid ? target_d : T_NONE;
      rsp_viol     <= req_valid & viol_d;
      rsp_lds_off  <= (req_valid && target_d == T_LDS)  ? sh_delta[LDS_W-1:0] : '0;
      rsp_priv_off <= (req_valid && target_d == T_PRIV) ? priv_d : '0;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_target == T_NONE && !rsp_viol && rsp_lds_off == '0 && rsp_priv_off == '0));
  p_viol_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_viol) |-> (rsp_target == T_NONE && rsp_lds_off == '0 && rsp_priv_off == '0));
  p_lds_off_scope_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_target != T_LDS) |-> (rsp_lds_off == '0));
  p_priv_off_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_target != T_PRIV) |-> (rsp_priv_off == '0));
  p_served_has_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_viol) |-> (rsp_target != T_NONE));

endmodule

// File: tb/flat_aperture_router_test.sv
`timescale 1ns/1ps
module flat_aperture_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_bytes = '0;
  logic [9:0]  req_tid = '0;
  logic        cfg_atc = 1'b1, cfg_ptr32 = 1'b0;
  logic [47:0] cfg_sh_base = '0, cfg_sh_limit = '0, cfg_pr_base = '0, cfg_pr_limit = '0;
  logic [15:0] cfg_stride = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_target;
  logic [31:0] rsp_lds_off;
  logic [47:0] rsp_priv_off;
  logic        rsp_viol;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flat_aperture_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_tid(req_tid), .cfg_atc(cfg_atc), .cfg_ptr32(cfg_ptr32),
    .cfg_sh_base(cfg_sh_base), .cfg_sh_limit(cfg_sh_limit), .cfg_pr_base(cfg_pr_base),
    .cfg_pr_limit(cfg_pr_limit), .cfg_stride(cfg_stride), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_lds_off(rsp_lds_off), .rsp_priv_off(rsp_priv_off),
    .rsp_viol(rsp_viol)
  );

  task automatic check(input string req, input logic ev, input logic [1:0] et,
                       input logic [31:0] el, input logic [47:0] ep, input logic ex);
    checks++;
    if (rsp_valid !== ev || rsp_target !== et || rsp_lds_off !== el || rsp_priv_off !== ep || rsp_viol !== ex) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0d lds=%h priv=%h viol=%0b, expected v=%0b t=%0d lds=%h priv=%h viol=%0b",
               req, rsp_valid, rsp_target, rsp_lds_off, rsp_priv_off, rsp_viol, ev, et, el, ep, ex);
    end
  endtask

  task automatic access(input string req, input logic [63:0] a, input logic [7:0] n, input logic [9:0] tid,
                        input logic [1:0] et, input logic [31:0] el, input logic [47:0] ep, input logic ex);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_bytes = n; req_tid = tid;
    @(posedge clk); #1;
    check(req, 1'b1, et, el, ep, ex);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set64();
    cfg_atc = 1'b1; cfg_ptr32 = 1'b0;
    cfg_sh_base = 48'h0001_0000_0000; cfg_sh_limit = 48'h0001_0000_FFFF;
    cfg_pr_base = 48'h0002_0000_0000; cfg_pr_limit = 48'h0002_0000_FFFF;
    cfg_stride = 16'h0400;
  endtask

  task automatic t_reset();
    #1;
    check("R1 during reset", 1'b0, 2'd0, 32'h0, 48'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 1'b0, 2'd0, 32'h0, 48'h0, 1'b0);
  endtask

  task automatic t_shared64();
    set64();
    access("R3 shared base", 64'h0001_0000_0000_0000, 8'd4, 10'd0, 2'd1, 32'h0, 48'h0, 1'b0);
    access("R3 shared limit byte", 64'h0001_0000_FFFF_FFFF, 8'd1, 10'd0, 2'd1, 32'hFFFF_FFFF, 48'h0, 1'b0);
    access("R7 zero size as one byte", 64'h0001_0000_FFFF_FFFF, 8'd0, 10'd0, 2'd1, 32'hFFFF_FFFF, 48'h0, 1'b0);
  endtask

  task automatic t_private64();
    set64();
    access("R4 private expand", 64'h0002_0000_0000_0100, 8'd4, 10'd3, 2'd2, 32'h0, 48'h0000_0000_0D00, 1'b0);
    access("R4 private limit", 64'h0002_0000_FFFF_FFFC, 8'd4, 10'd0, 2'd2, 32'h0, 48'h0000_FFFF_FFFC, 1'b0);
  endtask

  task automatic t_global_hole();
    set64();
    access("R5 global low", 64'h0000_0000_1234_5678, 8'd16, 10'd1, 2'd3, 32'h0, 48'h0, 1'b0);
    access("R5 global high", 64'hFFFF_8000_0000_0000, 8'd8, 10'd1, 2'd3, 32'h0, 48'h0, 1'b0);
    access("R6 hole", 64'h0003_0000_0000_0000, 8'd4, 10'd0, 2'd0, 32'h0, 48'h0, 1'b1);
    access("R7 shared into hole", 64'h0001_0000_FFFF_FFFE, 8'd4, 10'd0, 2'd0, 32'h0, 48'h0, 1'b1);
    access("R7 global into hole", 64'h0000_7FFF_FFFF_FFFE, 8'd4, 10'd0, 2'd0, 32'h0, 48'h0, 1'b1);
  endtask

  task automatic t_mode32();
    set64();
    cfg_ptr32 = 1'b1;
    access("R8 64b apertures unused in 32b", 64'h0001_0000_0000_0000, 8'd4, 10'd0, 2'd3, 32'h0, 48'h0, 1'b0);
    cfg_sh_base = 48'h0000_0000_1000; cfg_sh_limit = 48'h0000_0000_2000;
    cfg_pr_base = 48'h0000_0000_3000; cfg_stride = 16'h0100;
    access("R8 shared 32b", 64'h0000_0000_1000_0010, 8'd4, 10'd0, 2'd1, 32'h10, 48'h0, 1'b0);
    access("R8 upper bits ignored", 64'hDEAD_BEEF_1000_0020, 8'd4, 10'd0, 2'd1, 32'h20, 48'h0, 1'b0);
    access("R8 fixed 64KB size", 64'h0000_0000_1001_0000, 8'd4, 10'd0, 2'd3, 32'h0, 48'h0, 1'b0);
    access("R8 straddle out of 64KB", 64'h0000_0000_1000_FFFE, 8'd4, 10'd0, 2'd0, 32'h0, 48'h0, 1'b1);
    access("R8 private 32b", 64'h0000_0000_3000_0040, 8'd4, 10'd2, 2'd2, 32'h0, 48'h0000_0000_0240, 1'b0);
    cfg_sh_base = 48'h0; cfg_sh_limit = 48'h0000_0000_FFFF;
    access("R8 zero base disables", 64'h0000_0000_0000_0010, 8'd4, 10'd0, 2'd3, 32'h0, 48'h0, 1'b0);
  endtask

  task automatic t_mode_ignore();
    set64();
    cfg_atc = 1'b0; cfg_ptr32 = 1'b1;
    access("R9 ptr32 ignored", 64'h0001_0000_0000_0008, 8'd4, 10'd0, 2'd1, 32'h8, 48'h0, 1'b0);
  endtask

  task automatic t_overlap();
    set64();
    cfg_pr_base = cfg_sh_base; cfg_pr_limit = cfg_sh_limit;
    access("R10 shared wins", 64'h0001_0000_0000_0020, 8'd4, 10'd5, 2'd1, 32'h20, 48'h0, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk); req_valid = 1'b0; req_addr = 64'h0001_0000_0000_0004;
    @(posedge clk); #1;
    check("R2 idle output", 1'b0, 2'd0, 32'h0, 48'h0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_shared64();
    t_private64();
    t_global_hole();
    t_mode32();
    t_mode_ignore();
    t_overlap();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule